// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the write and read cycles on the host side of a flash memory. It picks out multi-cycle extended commands from the low byte of the data bus. After an opcode arrives, it waits for the cycles that belong to that command, checks any confirm byte or sub-code, and captures the address and operands those cycles carry. When a sequence is complete and valid, it raises a one-cycle strobe with the opcode, the address of the last cycle and a 16-bit operand. A sequence that fails its check is dropped, and a one-cycle error pulse is raised in its place.

The block also holds the configuration register for the ready/busy output. Sub-command 96H updates that register. The byte/word mode input is sampled on the opcode cycle. It decides whether the two-part operand of a page-buffer-to-flash or two-byte program is ordered by address bit 0. All outputs are registered, so a strobe appears one clock after the cycle that completes the sequence.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, cmd_valid and cmd_err are low, busy is low and rb_mode is 1 (level mode). A reset in the middle of a sequence discards it.
- R2: A write whose low data byte is 72H or F0H produces a strobe on the next clock, with cmd_op equal to that byte, cmd_addr equal to the cycle address and cmd_data 0. Data bits above bit 7 are ignored.
- R3: After 71H or 75H, the next read produces a strobe carrying that opcode and the read address. After 74H, the next write produces a strobe with opcode 74H, its address and the full data word.
- R4: After 77H, 97H, 99H or A7H, a write with low byte D0H produces a strobe with that opcode, the confirm-cycle address and cmd_data 0.
- R5: A confirm write whose low byte is not D0H produces a cmd_err pulse and no strobe, and returns the decoder to idle.
- R6: After 96H, a write with low byte 01H to 05H stores the value in rb_mode and strobes opcode 96H, with cmd_data equal to the value. Any other value raises cmd_err and leaves rb_mode unchanged.
- R7: In byte mode (byte_mode=1 on the opcode cycle), 0CH and FBH take two further writes. On the second, address bit 0 = 1 means the high byte comes first and 0 means the low byte comes first. The third write carries the other byte. The strobe gives cmd_data = {high, low} and cmd_addr = the third-cycle address.
- R8: Opcode E0H (either mode), and 0CH in word mode, take two further writes: low byte, then high byte. Address bit 0 has no effect. The strobe gives cmd_data = {high, low} and cmd_addr = the third-cycle address.
- R9: A write with low byte 80H, on any cycle, strobes opcode 80H with cmd_data 0 and discards any partial sequence.
- R10: Writes with an unrecognised low byte are ignored, including FBH in word mode. Reads are ignored while the decoder is idle and while it waits for a write.
- R11: A write other than 80H, arriving while the decoder waits for the read of 71H or 75H, raises cmd_err and returns to idle.
- R12: cmd_valid and cmd_err each last one cycle and are never high together. busy is high exactly while a sequence is partly received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write bus cycle in this clock |
| rd_en | input | 1 | Read bus cycle in this clock (write wins if both) |
| addr | input | AW | Bus address |
| wdata | input | DW | Write data; the low byte is decoded |
| byte_mode | input | 1 | 1 = byte-wide bus, 0 = word-wide bus |
| cmd_valid | output | 1 | One-cycle strobe for a completed command |
| cmd_err | output | 1 | One-cycle pulse for a rejected sequence |
| cmd_op | output | 8 | Decoded opcode |
| cmd_addr | output | AW | Address of the completing cycle |
| cmd_data | output | DW | Captured operand |
| rb_mode | output | 3 | Ready/busy configuration (1..5) |
| busy | output | 1 | Sequence partly received |

## Verification
A wrong internal state shows up within one clock at the ports. A lost sequence state makes the completing cycle give either no strobe or a stray error pulse. A wrong stored opcode or byte order shows up in cmd_op or cmd_data in the strobe cycle. A stale state after abort or after an error is caught by the single-cycle command that follows, which must strobe at once. busy is sampled in the middle of a sequence. rb_mode is read back after both accepted and rejected sub-codes.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          byte_mode,
  output logic          cmd_valid,
  output logic          cmd_err,
  output logic [7:0]    cmd_op,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic [2:0]    rb_mode,
  output logic          busy
);
  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_CONF, S_RB, S_P2, S_P3} st_t;
  st_t st;
  logic [7:0] op, first;
  logic       bm, hi_first;
  wire  [7:0] lo = wdata[7:0];

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= '0; first <= '0; bm <= 1'b0; hi_first <= 1'b0;
      cmd_valid <= 1'b0; cmd_err <= 1'b0; cmd_op <= '0; cmd_addr <= '0;
      cmd_data <= '0; rb_mode <= 3'd1;
    end else begin
      cmd_valid <= 1'b0;
      cmd_err   <= 1'b0;
      if (wr_en && lo == 8'h80) begin
        cmd_valid <= 1'b1; cmd_op <= 8'h80; cmd_addr <= addr; cmd_data <= '0;
        st <= S_IDLE;
      end else begin
        unique case (st)
          S_IDLE: if (wr_en) begin
            op <= lo;
            bm <= byte_mode;
            case (lo)
              8'h72, 8'hF0: begin
                cmd_valid <= 1'b1; cmd_op <= lo; cmd_addr <= addr; cmd_data <= '0;
              end
              8'h71, 8'h75:                st <= S_RD;
              8'h74:                       st <= S_WR;
              8'h77, 8'h97, 8'h99, 8'hA7:  st <= S_CONF;
              8'h96:                       st <= S_RB;
              8'h0C, 8'hE0:                st <= S_P2;
              8'hFB: if (byte_mode)        st <= S_P2;
              default: ;
            endcase
          end
          S_RD: if (wr_en) begin
            cmd_err <= 1'b1; st <= S_IDLE;
          end else if (rd_en) begin
            cmd_valid <= 1'b1; cmd_op <= op; cmd_addr <= addr; cmd_data <= '0;
            st <= S_IDLE;
          end
          S_WR: if (wr_en) begin
            cmd_valid <= 1'b1; cmd_op <= op; cmd_addr <= addr; cmd_data <= wdata;
            st <= S_IDLE;
          end
          S_CONF: if (wr_en) begin
            if (lo == 8'hD0) begin
              cmd_valid <= 1'b1; cmd_op <= op; cmd_addr <= addr; cmd_data <= '0;
            end else cmd_err <= 1'b1;
            st <= S_IDLE;
          end
          S_RB: if (wr_en) begin
            if (lo >= 8'h01 && lo <= 8'h05) begin
              rb_mode <= lo[2:0];
              cmd_valid <= 1'b1; cmd_op <= op; cmd_addr <= addr; cmd_data <= DW'(lo);
            end else cmd_err <= 1'b1;
            st <= S_IDLE;
          end
          S_P2: if (wr_en) begin
            first    <= lo;
            hi_first <= bm && (op != 8'hE0) && addr[0];
            st       <= S_P3;
          end
          S_P3: if (wr_en) begin
            cmd_valid <= 1'b1; cmd_op <= op; cmd_addr <= addr;
            cmd_data  <= hi_first ? DW'({first, lo}) : DW'({lo, first});
            st        <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module flash_cmd_decoder_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [DW-1:0] wdata,
  input logic          busy,
  input logic          cmd_valid,
  input logic          cmd_err,
  input logic [7:0]    cmd_op,
  input logic [2:0]    rb_mode
);
  assert_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_err));
  assert_err_from_seq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(busy));
  assert_rb_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rb_mode >= 3'd1 && rb_mode <= 3'd5);
  assert_rb_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(rb_mode)) |-> ($past(wr_en && busy) && cmd_valid && cmd_op == 8'h96));
  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && wr_en && wdata[7:0] == 8'h80) |-> (cmd_valid && cmd_op == 8'h80 && !busy));
  assert_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && wr_en && !busy && !(wdata[7:0] inside
      {8'h72, 8'hF0, 8'h71, 8'h75, 8'h74, 8'h77, 8'h97, 8'h99, 8'hA7,
       8'h96, 8'h0C, 8'hE0, 8'hFB, 8'h80})) |-> (!busy && !cmd_valid && !cmd_err));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .busy(busy),
  .cmd_valid(cmd_valid), .cmd_err(cmd_err), .cmd_op(cmd_op), .rb_mode(rb_mode));

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/100ps
module tb_flash_cmd_decoder;
  localparam int AW = 21;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, byte_mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic cmd_valid, cmd_err, busy;
  logic [7:0] cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic [2:0] rb_mode;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.AW(AW), .DW(DW)) dut (.*);

  typedef struct packed {
    logic wr; logic rd; logic [AW-1:0] a; logic [DW-1:0] d; logic bm;
    logic v; logic e; logic [7:0] op; logic [AW-1:0] ea; logic [DW-1:0] ed;
    logic [7:0] req;
  } vec_t;

  localparam int N = 37;
  localparam vec_t TAB [N] = '{
    '{1'b1,1'b0,21'h5,16'hAB72,1'b0, 1'b1,1'b0,8'h72,21'h5,16'h0, 8'd2},    // R2 upper bits ignored
    '{1'b1,1'b0,21'h0,16'h0071,1'b0, 1'b0,1'b0,8'h0,21'h0,16'h0, 8'd3},     // R3
    '{1'b0,1'b1,21'h1234,16'h0,1'b0, 1'b1,1'b0,8'h71,21'h1234,16'h0, 8'd3},
    '{1'b1,1'b0,21'h0,16'h0074,1'b0, 1'b0,1'b0,8'h0,21'h0,16'h0, 8'd3},
    '{1'b1,1'b0,21'h40,16'hBEEF,1'b0, 1'b1,1'b0,8'h74,21'h40,16'hBEEF, 8'd3},
    '{1'b1,1'b0,21'h0,16'h0077,1'b0, 1'b0,1'b0,8'h0,21'h0,16'h0, 8'd4},     // R4
    '{1'b1,1'b0,21'h1F0000,16'h00D0,1'b0, 1'b1,1'b0,8'h77,21'h1F0000,16'h0, 8'd4},
    '{1'b1,1'b0,21'h0,16'h00A7,1'b0, 1'b0,1'b0,8'h0,21'h0,16'h0, 8'd5},     // R5
    '{1'b1,1'b0,21'h3,16'h00D1,1'b0, 1'b0,1'b1,8'h0,21'h0,16'h0, 8'd5},
    '{1'b1,1'b0,21'h0,16'h0096,1'b0, 1'b0,1'b0,8'h0,21'h0,16'h0, 8'd6},     // R6
    '{1'b1,1'b0,21'h0,16'h0003,1'b0, 1'b1,1'b0,8'h96,21'h0,16'h3, 8'd6},
    '{1'b1,1'b0,21'h0,16'h0096,1'b0, 1'b0,1'b0,8'h0,21'h0,16'h0, 8'd6},
    '{1'b1,1'b0,21'h0,16'h0007,1'b0, 1'b0,1'b1,8'h0,21'h0,16'h0, 8'd6},
    '{1'b1,1'b0,21'h0,16'h0055,1'b0, 1'b0,1'b0,8'h0,21'h0,16'h0, 8'd10},    // R10
    '{1'b1,1'b0,21'h0,16'h00FB,1'b0, 1'b0,1'b0,8'h0,21'h0,16'h0, 8'd10},
    '{1'b1,1'b0,21'h0,16'h0072,1'b0, 1'b1,1'b0,8'h72,21'h0,16'h0, 8'd10},
    '{1'b1,1'b0,21'h0,16'h000C,1'b1, 1'b0,1'b0,8'h0,21'h0,16'h0, 8'd7},     // R7 high first
    '{1'b1,1'b0,21'h1,16'h0012,1'b1, 1'b0,1'b0,8'h0,21'h0,16'h0, 8'd7},
    '{1'b1,1'b0,21'h2000,16'h0034,1'b1, 1'b1,1'b0,8'h0C,21'h2000,16'h1234, 8'd7},
    '{1'b1,1'b0,21'h0,16'h00FB,1'b1, 1'b0,1'b0,8'h0,21'h0,16'h0, 8'd7},     // R7 low first
    '{1'b1,1'b0,21'h0,16'h0056,1'b1, 1'b0,1'b0,8'h0,21'h0,16'h0, 8'd7},
    '{1'b1,1'b0,21'h77,16'h009A,1'b1, 1'b1,1'b0,8'hFB,21'h77,16'h9A56, 8'd7},
    '{1'b1,1'b0,21'h0,16'h000C,1'b0, 1'b0,1'b0,8'h0,21'h0,16'h0, 8'd8},     // R8 word mode
    '{1'b1,1'b0,21'h1,16'h0011,1'b0, 1'b0,1'b0,8'h0,21'h0,16'h0, 8'd8},
    '{1'b1,1'b0,21'h300,16'h0022,1'b0, 1'b1,1'b0,8'h0C,21'h300,16'h2211, 8'd8},
    '{1'b1,1'b0,21'h0,16'h00E0,1'b1, 1'b0,1'b0,8'h0,21'h0,16'h0, 8'd8},
    '{1'b1,1'b0,21'h1,16'h0005,1'b1, 1'b0,1'b0,8'h0,21'h0,16'h0, 8'd8},
    '{1'b1,1'b0,21'h9,16'h0001,1'b1, 1'b1,1'b0,8'hE0,21'h9,16'h0105, 8'd8},
    '{1'b1,1'b0,21'h0,16'h0099,1'b0, 1'b0,1'b0,8'h0,21'h0,16'h0, 8'd9},     // R9
    '{1'b1,1'b0,21'h4,16'h0080,1'b0, 1'b1,1'b0,8'h80,21'h4,16'h0, 8'd9},
    '{1'b1,1'b0,21'h0,16'h0075,1'b0, 1'b0,1'b0,8'h0,21'h0,16'h0, 8'd11},    // R11
    '{1'b1,1'b0,21'h2,16'h0000,1'b0, 1'b0,1'b1,8'h0,21'h0,16'h0, 8'd11},
    '{1'b1,1'b0,21'h0,16'h0074,1'b0, 1'b0,1'b0,8'h0,21'h0,16'h0, 8'd10},    // R10 read ignored
    '{1'b0,1'b1,21'h8,16'h0,1'b0, 1'b0,1'b0,8'h0,21'h0,16'h0, 8'd10},
    '{1'b1,1'b0,21'h8,16'h1111,1'b0, 1'b1,1'b0,8'h74,21'h8,16'h1111, 8'd10},
    '{1'b0,1'b0,21'h0,16'h0,1'b0, 1'b0,1'b0,8'h0,21'h0,16'h0, 8'd12},       // R12 strobe drops
    '{1'b1,1'b0,21'h6,16'h00F0,1'b0, 1'b1,1'b0,8'hF0,21'h6,16'h0, 8'd2}
  };

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cycle(input logic w, input logic r, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic bm);
    wr_en = w; rd_en = r; addr = a; wdata = d; byte_mode = bm;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!cmd_valid && !cmd_err && !busy, "R1", "flags in reset",
          {cmd_valid, cmd_err, busy}, 3'b000);
    check(rb_mode == 3'd1, "R1", "rb_mode in reset", rb_mode, 3'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < N; i++) begin
      cycle(TAB[i].wr, TAB[i].rd, TAB[i].a, TAB[i].d, TAB[i].bm);
      if (TAB[i].v)
        check(cmd_valid && !cmd_err && cmd_op == TAB[i].op && cmd_addr == TAB[i].ea
              && cmd_data == TAB[i].ed, $sformatf("R%0d", TAB[i].req),
              $sformatf("vector %0d strobe op/addr/data", i),
              {cmd_valid, cmd_err, cmd_op, cmd_addr, cmd_data},
              {1'b1, 1'b0, TAB[i].op, TAB[i].ea, TAB[i].ed});
      else
        check(cmd_valid == 1'b0 && cmd_err == TAB[i].e, $sformatf("R%0d", TAB[i].req),
              $sformatf("vector %0d valid/err", i), {cmd_valid, cmd_err}, {1'b0, TAB[i].e});
    end

    // R6 rejected sub-code kept earlier mode
    check(rb_mode == 3'd3, "R6", "rb_mode after rejected sub-code", rb_mode, 3'd3);

    // R12 busy while partial, clear when done
    cycle(1'b1, 1'b0, '0, 16'h0097, 1'b0);
    check(busy && !cmd_valid, "R12", "busy mid-sequence", {busy, cmd_valid}, 2'b10);
    cycle(1'b1, 1'b0, 21'h55, 16'h00D0, 1'b0);
    check(!busy && cmd_valid && cmd_op == 8'h97, "R12", "busy cleared at strobe",
          {busy, cmd_valid, cmd_op}, {2'b01, 8'h97});

    // R1 reset mid-sequence
    cycle(1'b1, 1'b0, '0, 16'h0096, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(!busy && rb_mode == 3'd1, "R1", "reset mid-sequence", {busy, rb_mode}, {1'b0, 3'd1});
    cycle(1'b1, 1'b0, '0, 16'h0002, 1'b0);
    check(!cmd_valid && !cmd_err && rb_mode == 3'd1, "R1", "sub-code after reset ignored",
          {cmd_valid, cmd_err, rb_mode}, {2'b00, 3'd1});

    // R9 abort during two-part operand
    cycle(1'b1, 1'b0, '0, 16'h00E0, 1'b0);
    cycle(1'b1, 1'b0, '0, 16'h0010, 1'b0);
    cycle(1'b1, 1'b0, 21'hA, 16'h5580, 1'b0);
    check(cmd_valid && cmd_op == 8'h80 && !busy, "R9", "abort in operand phase",
          {cmd_valid, cmd_op, busy}, {1'b1, 8'h80, 1'b0});
    cycle(1'b1, 1'b0, '0, 16'h0020, 1'b0);
    check(!cmd_valid && !cmd_err && !busy, "R9", "no resumed sequence",
          {cmd_valid, cmd_err, busy}, 3'b000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule